// File: doc/BRIEF.md
# Pipelined Complex Radix-2 Butterfly

This block combines two complex signed-integer operands `a` and `b` with a complex twiddle factor `W` and produces the sum pair `A = a + b·W` and `B = a − b·W`. Each operand has separate real and imaginary parts. The arithmetic runs at full precision. The internal result of every component is two input widths plus two bits wide, so no combination of input values can overflow it.

The datapath is fully pipelined and accepts a fresh operand set on every enabled clock. The total latency equals the `PIPE_DEPTH` parameter, which must be at least 3. Three stages compute the result: products first, then cross terms, then the final add and subtract. The remaining stages are plain delay registers at the tail. A clock enable freezes the whole pipeline. An asynchronous clear zeroes every pipeline register at once.

At the output there are two choices. The block can present the whole internal result, or it can present a window of `OUT_W` bits starting at bit `OUT_LSB`. The window drops the bits below it and wraps the bits above it. The twiddle factor can be taken from the twiddle ports, or it can be fixed through parameters, in which case those ports are ignored.

Top module: `cplx_butterfly`

## Requirements
- R1: Real part of A equals x + y·v − Y·V and imaginary part equals X + Y·v + y·V, where a = x + jX, b = y + jY, W = v + jV, all two's-complement signed.
- R2: Real part of B equals x − y·v + Y·V and imaginary part equals X − Y·v − y·V.
- R3: With FULL_RES = 1 each output component is 2·IN_W + 2 bits wide and carries the exact result, including when every operand is the most negative or most positive value.
- R4: With FULL_RES = 0 each output component is OUT_W bits wide and equals bits [OUT_LSB + OUT_W − 1 : OUT_LSB] of the exact result: lower bits dropped without rounding, upper bits discarded so the value wraps.
- R5: An operand set sampled on an enabled rising edge appears on the outputs after exactly PIPE_DEPTH enabled rising edges (PIPE_DEPTH ≥ 3).
- R6: A new operand set may be applied on every enabled clock, and each one yields its own result PIPE_DEPTH edges later.
- R7: While `ceIn` is low, every pipeline register holds its value: the outputs do not change and the operands presented meanwhile are never captured.
- R8: While `clrAsync` is high, every pipeline register and therefore every output reads zero, without waiting for a clock edge.
- R9: With CONST_TW = 1 the twiddle is TW_RE + j·TW_IM and the values on `twRe`/`twIm` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clrAsync | input | 1 | Asynchronous clear of all pipeline registers, active high |
| ceIn | input | 1 | Clock enable; low freezes the pipeline |
| aRe | input | IN_W | Real part of operand a, signed |
| aIm | input | IN_W | Imaginary part of operand a, signed |
| bRe | input | IN_W | Real part of operand b, signed |
| bIm | input | IN_W | Imaginary part of operand b, signed |
| twRe | input | IN_W | Real part of twiddle W, signed; ignored when CONST_TW = 1 |
| twIm | input | IN_W | Imaginary part of twiddle W, signed; ignored when CONST_TW = 1 |
| outARe | output | FULL_RES ? 2·IN_W+2 : OUT_W | Real part of A, signed |
| outAIm | output | FULL_RES ? 2·IN_W+2 : OUT_W | Imaginary part of A, signed |
| outBRe | output | FULL_RES ? 2·IN_W+2 : OUT_W | Real part of B, signed |
| outBIm | output | FULL_RES ? 2·IN_W+2 : OUT_W | Imaginary part of B, signed |

## Verification
The product-range and sum/difference properties are checked against any two's-complement operand values. They assume the parameters are legal: a depth of at least 3, and a slice that fits inside the internal width. The clear is assumed to be raised before the first edge that matters, so every register starts from a known zero. The stimulus respects both assumptions. It uses legal parameter sets, asserts the clear at time zero, and changes operands, enable and clear only on falling edges. Raising the clear halfway between edges still checks that the clear acts without a clock. The operand patterns include every corner combination of the most negative and most positive values, so the no-overflow property is tested where it is tightest.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Per-stage advance strobes issued by the control to the datapath.
  typedef struct packed {
    logic advMul;    // product stage
    logic advCross;  // cross-term stage
    logic advSum;    // final add/subtract stage
    logic advDly;    // tail delay registers
  } bfly_strobe_t;

  function automatic int fullWidth(input int inW);
    return 2 * inW + 2;
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic         ceIn,
  output bfly_strobe_t strobe
);

  // All stages move in lockstep: one enable freezes or advances the whole pipe.
  always_comb begin
    strobe.advMul   = ceIn;
    strobe.advCross = ceIn;
    strobe.advSum   = ceIn;
    strobe.advDly   = ceIn;
  end

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter bit CONST_TW = 1'b0,
  parameter int TW_RE    = 1,
  parameter int TW_IM    = 0
) (
  input  logic                       clk,
  input  logic                       clrAsync,
  input  bfly_strobe_t               strobe,
  input  logic signed [IN_W-1:0]     aRe,
  input  logic signed [IN_W-1:0]     aIm,
  input  logic signed [IN_W-1:0]     bRe,
  input  logic signed [IN_W-1:0]     bIm,
  input  logic signed [IN_W-1:0]     twRe,
  input  logic signed [IN_W-1:0]     twIm,
  output logic signed [2*IN_W+1:0]   sumARe,
  output logic signed [2*IN_W+1:0]   sumAIm,
  output logic signed [2*IN_W+1:0]   sumBRe,
  output logic signed [2*IN_W+1:0]   sumBIm
);

  localparam int W2 = 2 * IN_W;        // product width
  localparam int W3 = 2 * IN_W + 1;    // cross-term width
  localparam int FW = fullWidth(IN_W); // final width
  localparam logic signed [IN_W-1:0] CONST_RE = IN_W'(TW_RE);
  localparam logic signed [IN_W-1:0] CONST_IM = IN_W'(TW_IM);
  localparam logic signed [W2-1:0] MAX_P = W2'(longint'(1) <<< (W2 - 2));
  localparam logic signed [W2-1:0] MIN_P =
    W2'(-((longint'(1) <<< (W2 - 2)) - (longint'(1) <<< (IN_W - 1))));

  // Twiddle source: fixed parameter value or live ports.
  logic signed [IN_W-1:0] wRe, wIm;
  assign wRe = CONST_TW ? CONST_RE : twRe;
  assign wIm = CONST_TW ? CONST_IM : twIm;

  // Stage 1: four partial products, operand a carried alongside.
  logic signed [W2-1:0]   pRr, pIi, pIr, pRi;
  logic signed [IN_W-1:0] aReS1, aImS1;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      pRr   <= '0;
      pIi   <= '0;
      pIr   <= '0;
      pRi   <= '0;
      aReS1 <= '0;
      aImS1 <= '0;
    end else if (strobe.advMul) begin
      pRr   <= W2'(bRe) * W2'(wRe);
      pIi   <= W2'(bIm) * W2'(wIm);
      pIr   <= W2'(bIm) * W2'(wRe);
      pRi   <= W2'(bRe) * W2'(wIm);
      aReS1 <= aRe;
      aImS1 <= aIm;
    end
  end

  // Stage 2: complex product b*W as two cross terms.
  logic signed [W3-1:0]   crossRe, crossIm;
  logic signed [IN_W-1:0] aReS2, aImS2;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      crossRe <= '0;
      crossIm <= '0;
      aReS2   <= '0;
      aImS2   <= '0;
    end else if (strobe.advCross) begin
      crossRe <= W3'(pRr) - W3'(pIi);
      crossIm <= W3'(pIr) + W3'(pRi);
      aReS2   <= aReS1;
      aImS2   <= aImS1;
    end
  end

  // Stage 3: butterfly add and subtract at full width.
  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      sumARe <= '0;
      sumAIm <= '0;
      sumBRe <= '0;
      sumBIm <= '0;
    end else if (strobe.advSum) begin
      sumARe <= FW'(aReS2) + FW'(crossRe);
      sumAIm <= FW'(aImS2) + FW'(crossIm);
      sumBRe <= FW'(aReS2) - FW'(crossRe);
      sumBIm <= FW'(aImS2) - FW'(crossIm);
    end
  end

  // Checker views: A+B must be twice a, A-B twice the cross term.
  logic signed [FW:0] chkSumRe, chkSumIm, chkDiffRe, chkDiffIm;
  logic signed [FW:0] twoARe, twoAIm, twoCrossRe, twoCrossIm;
  assign chkSumRe   = (FW+1)'(sumARe) + (FW+1)'(sumBRe);
  assign chkSumIm   = (FW+1)'(sumAIm) + (FW+1)'(sumBIm);
  assign chkDiffRe  = (FW+1)'(sumARe) - (FW+1)'(sumBRe);
  assign chkDiffIm  = (FW+1)'(sumAIm) - (FW+1)'(sumBIm);
  assign twoARe     = (FW+1)'(aReS2) <<< 1;
  assign twoAIm     = (FW+1)'(aImS2) <<< 1;
  assign twoCrossRe = (FW+1)'(crossRe) <<< 1;
  assign twoCrossIm = (FW+1)'(crossIm) <<< 1;

  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (clrAsync)
    (pRr >= MIN_P) && (pRr <= MAX_P) && (pIi >= MIN_P) && (pIi <= MAX_P) &&
    (pIr >= MIN_P) && (pIr <= MAX_P) && (pRi >= MIN_P) && (pRi <= MAX_P)); // R3

  AST_A_PLUS_B: assert property (@(posedge clk) disable iff (clrAsync)
    strobe.advSum |=> (chkSumRe == $past(twoARe)) && (chkSumIm == $past(twoAIm))); // R1

  AST_A_MINUS_B: assert property (@(posedge clk) disable iff (clrAsync)
    strobe.advSum |=> (chkDiffRe == $past(twoCrossRe)) && (chkDiffIm == $past(twoCrossIm))); // R2

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (clrAsync)
    !strobe.advSum |=> $stable(sumARe) && $stable(sumAIm) &&
                       $stable(sumBRe) && $stable(sumBIm)); // R7

  always @(posedge clk) begin
    if (clrAsync) begin
      AST_SUM_CLEAR: assert ((sumARe == '0) && (sumAIm == '0) &&
                             (sumBRe == '0) && (sumBIm == '0))
        else $error("stage-3 registers not cleared"); // R8
    end
  end

endmodule

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             clrAsync,
  input  logic             adv,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign dOut = dIn;
    end else begin : g_regs
      logic [WIDTH-1:0] tap [DEPTH+1];
      assign tap[0] = dIn;
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or posedge clrAsync) begin
          if (clrAsync) begin
            tap[i+1] <= '0;
          end else if (adv) begin
            tap[i+1] <= tap[i];
          end
        end
      end
      assign dOut = tap[DEPTH];

      AST_DLY_HOLD: assert property (@(posedge clk) disable iff (clrAsync)
        !adv |=> $stable(dOut)); // R7

      always @(posedge clk) begin
        if (clrAsync) begin
          AST_DLY_CLEAR: assert (dOut == '0)
            else $error("delay tail not cleared"); // R8
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cplx_butterfly.sv
module cplx_butterfly
  import bfly_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int PIPE_DEPTH = 4,
  parameter bit FULL_RES   = 1'b1,
  parameter int OUT_W      = 16,
  parameter int OUT_LSB    = 4,
  parameter bit CONST_TW   = 1'b0,
  parameter int TW_RE      = 1,
  parameter int TW_IM      = 0
) (
  input  logic                                            clk,
  input  logic                                            clrAsync,
  input  logic                                            ceIn,
  input  logic signed [IN_W-1:0]                          aRe,
  input  logic signed [IN_W-1:0]                          aIm,
  input  logic signed [IN_W-1:0]                          bRe,
  input  logic signed [IN_W-1:0]                          bIm,
  input  logic signed [IN_W-1:0]                          twRe,
  input  logic signed [IN_W-1:0]                          twIm,
  output logic signed [(FULL_RES ? 2*IN_W+2 : OUT_W)-1:0] outARe,
  output logic signed [(FULL_RES ? 2*IN_W+2 : OUT_W)-1:0] outAIm,
  output logic signed [(FULL_RES ? 2*IN_W+2 : OUT_W)-1:0] outBRe,
  output logic signed [(FULL_RES ? 2*IN_W+2 : OUT_W)-1:0] outBIm
);

  localparam int FW        = fullWidth(IN_W);
  localparam int RES_W     = FULL_RES ? FW : OUT_W;
  localparam int LSB_EFF   = FULL_RES ? 0 : OUT_LSB;
  localparam int COMPUTE_N = 3;
  localparam int TAIL_N    = PIPE_DEPTH - COMPUTE_N;

  bfly_strobe_t strobe;

  bfly_ctrl u_ctrl (
    .ceIn   (ceIn),
    .strobe (strobe)
  );

  logic signed [FW-1:0] sARe, sAIm, sBRe, sBIm;

  bfly_datapath #(
    .IN_W     (IN_W),
    .CONST_TW (CONST_TW),
    .TW_RE    (TW_RE),
    .TW_IM    (TW_IM)
  ) u_dp (
    .clk      (clk),
    .clrAsync (clrAsync),
    .strobe   (strobe),
    .aRe      (aRe),
    .aIm      (aIm),
    .bRe      (bRe),
    .bIm      (bIm),
    .twRe     (twRe),
    .twIm     (twIm),
    .sumARe   (sARe),
    .sumAIm   (sAIm),
    .sumBRe   (sBRe),
    .sumBIm   (sBIm)
  );

  logic [4*FW-1:0] tailIn, tailOut;
  assign tailIn = {sARe, sAIm, sBRe, sBIm};

  bfly_delay #(
    .WIDTH (4 * FW),
    .DEPTH (TAIL_N)
  ) u_tail (
    .clk      (clk),
    .clrAsync (clrAsync),
    .adv      (strobe.advDly),
    .dIn      (tailIn),
    .dOut     (tailOut)
  );

  logic signed [FW-1:0] fARe, fAIm, fBRe, fBIm;
  assign {fARe, fAIm, fBRe, fBIm} = tailOut;

  // Output window: shift the slice down, then keep the low RES_W bits (wraps).
  assign outARe = RES_W'(fARe >>> LSB_EFF);
  assign outAIm = RES_W'(fAIm >>> LSB_EFF);
  assign outBRe = RES_W'(fBRe >>> LSB_EFF);
  assign outBIm = RES_W'(fBIm >>> LSB_EFF);

  initial begin
    AST_DEPTH_MIN: assert (PIPE_DEPTH >= COMPUTE_N && IN_W >= 1)
      else $error("pipeline depth must be at least 3"); // R5
    AST_SLICE_FIT: assert (FULL_RES || (OUT_W >= 1 && OUT_LSB >= 0 && OUT_LSB + OUT_W <= FW))
      else $error("output slice outside internal width"); // R4
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (clrAsync)
    !ceIn |=> $stable(outARe) && $stable(outAIm) &&
              $stable(outBRe) && $stable(outBIm)); // R7

  always @(posedge clk) begin
    if (clrAsync) begin
      AST_OUT_CLEAR: assert ((outARe == '0) && (outAIm == '0) &&
                             (outBRe == '0) && (outBIm == '0))
        else $error("outputs not cleared"); // R8
    end
  end

endmodule

// File: tb/cplx_butterfly_tb.sv
module cplx_butterfly_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int FW         = 2 * N + 2;
  localparam int D_MAIN     = 4;
  localparam int D_SLICE    = 3;
  localparam int D_CONST    = 5;
  localparam int SL_W       = 8;
  localparam int SL_LSB     = 4;
  localparam int K_RE       = 90;
  localparam int K_IM       = -45;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic ce  = 1'b1;
  logic signed [N-1:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0, twRe = '0, twIm = '0;

  logic signed [FW-1:0]   mARe, mAIm, mBRe, mBIm;
  logic signed [SL_W-1:0] sARe, sAIm, sBRe, sBIm;
  logic signed [FW-1:0]   cARe, cAIm, cBRe, cBIm;

  int checks = 0;
  int failures = 0;

  int vX [64];
  int vXi[64];
  int vY [64];
  int vYi[64];
  int vV [64];
  int vVi[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_butterfly #(.IN_W(N), .PIPE_DEPTH(D_MAIN), .FULL_RES(1'b1)) u_dut (
    .clk(clk), .clrAsync(clr), .ceIn(ce), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .twRe(twRe), .twIm(twIm), .outARe(mARe), .outAIm(mAIm), .outBRe(mBRe), .outBIm(mBIm));

  cplx_butterfly #(.IN_W(N), .PIPE_DEPTH(D_SLICE), .FULL_RES(1'b0), .OUT_W(SL_W),
                   .OUT_LSB(SL_LSB)) u_dutSlice (
    .clk(clk), .clrAsync(clr), .ceIn(ce), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .twRe(twRe), .twIm(twIm), .outARe(sARe), .outAIm(sAIm), .outBRe(sBRe), .outBIm(sBIm));

  cplx_butterfly #(.IN_W(N), .PIPE_DEPTH(D_CONST), .FULL_RES(1'b1), .CONST_TW(1'b1),
                   .TW_RE(K_RE), .TW_IM(K_IM)) u_dutConst (
    .clk(clk), .clrAsync(clr), .ceIn(ce), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .twRe(twRe), .twIm(twIm), .outARe(cARe), .outAIm(cAIm), .outBRe(cBRe), .outBIm(cBIm));

  // Behavioural model of the butterfly.
  function automatic void bfly(input longint x, input longint xi, input longint y,
                               input longint yi, input longint v, input longint vi,
                               output longint ar, output longint ai,
                               output longint br, output longint bi);
    ar = x + y * v - yi * vi;
    ai = xi + yi * v + y * vi;
    br = x - y * v + yi * vi;
    bi = xi - yi * v - y * vi;
  endfunction

  function automatic longint sliceOf(input longint val);
    logic [63:0] t;
    logic signed [SL_W-1:0] s;
    t = val;
    s = t[SL_LSB +: SL_W];
    return longint'(s);
  endfunction

  task automatic checkVal(input string req, input string what, input longint act,
                          input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmpMain(input string rA, input string rB, input longint ar,
                         input longint ai, input longint br, input longint bi);
    checkVal(rA, "main A.re", longint'(mARe), ar);
    checkVal(rA, "main A.im", longint'(mAIm), ai);
    checkVal(rB, "main B.re", longint'(mBRe), br);
    checkVal(rB, "main B.im", longint'(mBIm), bi);
  endtask

  task automatic cmpSlice(input string r, input longint ar, input longint ai,
                          input longint br, input longint bi);
    checkVal(r, "slice A.re", longint'(sARe), sliceOf(ar));
    checkVal(r, "slice A.im", longint'(sAIm), sliceOf(ai));
    checkVal(r, "slice B.re", longint'(sBRe), sliceOf(br));
    checkVal(r, "slice B.im", longint'(sBIm), sliceOf(bi));
  endtask

  task automatic cmpConst(input string r, input longint ar, input longint ai,
                          input longint br, input longint bi);
    checkVal(r, "const A.re", longint'(cARe), ar);
    checkVal(r, "const A.im", longint'(cAIm), ai);
    checkVal(r, "const B.re", longint'(cBRe), br);
    checkVal(r, "const B.im", longint'(cBIm), bi);
  endtask

  task automatic cmpAllZero(input string r);
    cmpMain(r, r, 0, 0, 0, 0);
    cmpSlice(r, 0, 0, 0, 0);
    cmpConst(r, 0, 0, 0, 0);
  endtask

  task automatic setVec(input int i, input int x, input int xi, input int y,
                        input int yi, input int v, input int vi);
    vX[i] = x; vXi[i] = xi; vY[i] = y; vYi[i] = yi; vV[i] = v; vVi[i] = vi;
  endtask

  function automatic int rnd();
    return int'($urandom_range(255)) - 128;
  endfunction

  task automatic driveVec(input int i);
    aRe = N'(vX[i]); aIm = N'(vXi[i]); bRe = N'(vY[i]); bIm = N'(vYi[i]);
    twRe = N'(vV[i]); twIm = N'(vVi[i]);
  endtask

  task automatic driveZero();
    aRe = '0; aIm = '0; bRe = '0; bIm = '0; twRe = '0; twIm = '0;
  endtask

  task automatic driveJunk();
    aRe = N'(rnd()); aIm = N'(rnd()); bRe = N'(rnd()); bIm = N'(rnd());
    twRe = N'(rnd()); twIm = N'(rnd());
  endtask

  // Back-to-back stream: vector c is applied at falling edge c and checked at
  // falling edge c + depth of each instance. An empty tag uses the default ones.
  task automatic runStream(input int n, input string tag);
    longint ar, ai, br, bi;
    string tA, tB, tS, tC;
    tA = (tag == "") ? "R1" : tag;
    tB = (tag == "") ? "R2" : tag;
    tS = (tag == "") ? "R4" : tag;
    tC = (tag == "") ? "R9" : tag;
    for (int c = 0; c < n + D_CONST + 1; c++) begin
      @(negedge clk);
      if (c >= D_MAIN && c - D_MAIN < n) begin
        bfly(vX[c-D_MAIN], vXi[c-D_MAIN], vY[c-D_MAIN], vYi[c-D_MAIN],
             vV[c-D_MAIN], vVi[c-D_MAIN], ar, ai, br, bi);
        cmpMain(tA, tB, ar, ai, br, bi);
      end
      if (c >= D_SLICE && c - D_SLICE < n) begin
        bfly(vX[c-D_SLICE], vXi[c-D_SLICE], vY[c-D_SLICE], vYi[c-D_SLICE],
             vV[c-D_SLICE], vVi[c-D_SLICE], ar, ai, br, bi);
        cmpSlice(tS, ar, ai, br, bi);
      end
      if (c >= D_CONST && c - D_CONST < n) begin
        bfly(vX[c-D_CONST], vXi[c-D_CONST], vY[c-D_CONST], vYi[c-D_CONST],
             K_RE, K_IM, ar, ai, br, bi);
        cmpConst(tC, ar, ai, br, bi);
      end
      if (c < n) driveVec(c);
      else driveZero();
    end
  endtask

  task automatic clearPipe();
    @(negedge clk);
    clr = 1'b1;
    driveZero();
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    cmpAllZero("R8");
    clr = 1'b0;
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) setVec(i, rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
    runStream(40, "");
  endtask

  task automatic testThroughput();
    for (int i = 0; i < 30; i++) setVec(i, rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
    runStream(30, "R6");
  endtask

  task automatic testExtremes();
    for (int i = 0; i < 64; i++) begin
      setVec(i, i[0] ? 127 : -128, i[1] ? 127 : -128, i[2] ? 127 : -128,
             i[3] ? 127 : -128, i[4] ? 127 : -128, i[5] ? 127 : -128);
    end
    runStream(64, "R3");
  endtask

  task automatic testLatency();
    for (int i = 0; i < 8; i++) setVec(i, 0, 0, 0, 0, 0, 0);
    setVec(3, 100, -77, 55, -128, 127, 33);
    runStream(8, "R5");
  endtask

  task automatic testHold();
    longint ar, ai, br, bi, kr, ki, kbr, kbi;
    clearPipe();
    ce = 1'b1;
    setVec(0, -61, 44, 113, -90, 71, -128);
    bfly(-61, 44, 113, -90, 71, -128, ar, ai, br, bi);
    bfly(-61, 44, 113, -90, K_RE, K_IM, kr, ki, kbr, kbi);
    @(negedge clk);
    driveVec(0);
    @(negedge clk);
    ce = 1'b0;
    driveJunk();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cmpAllZero("R7");
      driveJunk();
    end
    ce = 1'b1;
    driveZero();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == D_MAIN - 1) cmpMain("R7", "R7", ar, ai, br, bi);
      else cmpMain("R7", "R7", 0, 0, 0, 0);
      if (k == D_SLICE - 1) cmpSlice("R7", ar, ai, br, bi);
      else cmpSlice("R7", 0, 0, 0, 0);
      if (k == D_CONST - 1) cmpConst("R7", kr, ki, kbr, kbi);
      else cmpConst("R7", 0, 0, 0, 0);
    end
  endtask

  task automatic testAsyncClear();
    ce = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      aRe = N'(100 + k); aIm = N'(-50); bRe = N'(90); bIm = N'(-70 + k);
      twRe = N'(120); twIm = N'(60);
    end
    @(negedge clk);
    #2 clr = 1'b1;
    #1 cmpAllZero("R8");
    @(negedge clk);
    clr = 1'b0;
    driveZero();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmpAllZero("R8");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testLatency();
    testRandom();
    testThroughput();
    testExtremes();
    testHold();
    testAsyncClear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule